// File: doc/BRIEF.md
# I/O Port Decoder with Sound-Generator Bus Control

This block sits between a CPU's I/O cycles and the peripherals of a small home-computer system. It classifies every I/O read or write by address. Any access with address bit 0 low reaches the system port. Writes to that port set the border colour, the speaker/tape output level and a tape-input enable. Reads from it return the keyboard columns of the rows named in the upper address byte, together with the tape input level.

Two exact 16-bit addresses belong to an external programmable sound generator (PSG) that uses a three-wire bus-control scheme (BDIR, BC2, BC1). The block turns CPU accesses to those addresses into one-cycle control pulses and holds the write data on the PSG data bus. For a read, it merges the PSG's output into the returned byte.

An access is presented as a one-cycle `io_req` strobe and is accepted on that clock edge. Register and PSG-control effects are visible in the following cycle. A read returns its byte with a one-cycle `rd_valid` after the next edge.

Top module: `io_port_decoder`

## Requirements
- R1: After reset, `border` = 0, `spk_out` = 0, `tape_en` = 0, all three PSG control lines are low, `rd_valid` = 0 and `rd_data` = 0xFF.
- R2: A write with `io_addr[0]` = 0 updates the system-port outputs, whatever the other 15 address bits are: `spk_out` takes data bit 4, `tape_en` takes data bit 3, and `border` takes data bits 2:0. The new values are visible in the cycle after the accepting edge.
- R3: Writes with `io_addr[0]` = 1, and all reads, leave `spk_out`, `tape_en` and `border` unchanged.
- R4: On a read with `io_addr[0]` = 0, `rd_data[4:0]` is the bitwise AND of the column groups of every selected row. Row r is selected when `io_addr[8+r]` = 0. Its columns are `key_matrix[5r+4:5r]`, and a 0 there means the key is pressed. When no row is selected, the result is 5'b11111.
- R5: On a read with `io_addr[0]` = 0, `rd_data[6]` equals `tape_in`, and bits 7 and 5 are 1.
- R6: A write to exactly 0xFFFD drives BDIR = BC2 = BC1 = 1 for the one cycle after the accepting edge, with `psg_dout` equal to the written byte.
- R7: A write to exactly 0xBFFD drives BDIR = 1, BC2 = 1 and BC1 = 0 for that one cycle, with `psg_dout` equal to the written byte.
- R8: A read from exactly 0xFFFD drives BDIR = 0, BC2 = 1 and BC1 = 1 for that one cycle. The returned byte is 0xFF ANDed with the `psg_din` value present in that cycle.
- R9: In every cycle that does not directly follow a PSG access, the three control lines are low. Addresses that differ from 0xFFFD or 0xBFFD in any bit produce no pulse.
- R10: A read from an odd address other than 0xFFFD returns 0xFF.
- R11: A read raises `rd_valid` for one cycle after the second edge following acceptance, with `rd_data` updated in that cycle and held until the next read. A write never raises `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | One-cycle I/O access strobe |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Full I/O address |
| io_wdata | input | 8 | Write data |
| key_matrix | input | 40 | Key columns, 5 per row, 8 rows, active low |
| tape_in | input | 1 | Tape input level |
| psg_din | input | 8 | Data returned by the sound generator |
| rd_data | output | 8 | Read result byte |
| rd_valid | output | 1 | Read result strobe |
| spk_out | output | 1 | Speaker / tape output level |
| tape_en | output | 1 | Stored tape-input enable |
| border | output | 3 | Border colour |
| psg_bdir | output | 1 | PSG bus direction control |
| psg_bc2 | output | 1 | PSG bus control 2 |
| psg_bc1 | output | 1 | PSG bus control 1 |
| psg_dout | output | 8 | Data bus towards the sound generator |

## Verification
The hardest case to reach is a keyboard read whose upper address byte selects several rows at once while keys are held in only some of them. Only then does the AND across rows differ from a single-row lookup. The stimulus draws random 40-bit key patterns and random row masks, and adds directed reads that select no rows, one row and all rows. Near-miss odd addresses and reads of the PSG data address check that the exact 16-bit match does not alias.

// File: rtl/iodec_pkg.sv
package iodec_pkg;

    localparam int BORDER_W = 3;

    typedef enum logic [1:0] {
        PSG_IDLE = 2'd0,
        PSG_SEL  = 2'd1,
        PSG_WR   = 2'd2,
        PSG_RD   = 2'd3
    } psg_op_e;

    typedef struct packed {
        logic                spk;
        logic                tape_en;
        logic [BORDER_W-1:0] border;
    } sys_state_t;

endpackage

// File: rtl/iodec_addr_match.sv
module iodec_addr_match
    import iodec_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 16'hFFFD,
    parameter logic [ADDR_W-1:0] DAT_ADDR = 16'hBFFD
) (
    input  logic              io_req,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              sys_wr,
    output logic              sys_rd,
    output psg_op_e           psg_op
);

    logic sys_hit;
    logic sel_hit;
    logic dat_hit;

    always_comb begin
        sys_hit = io_req && !io_addr[0];
        sel_hit = io_req && (io_addr == SEL_ADDR);
        dat_hit = io_req && (io_addr == DAT_ADDR);
        sys_wr  = sys_hit && io_wr;
        sys_rd  = sys_hit && !io_wr;
        psg_op  = PSG_IDLE;
        if (sel_hit && io_wr)       psg_op = PSG_SEL;
        else if (dat_hit && io_wr)  psg_op = PSG_WR;
        else if (sel_hit && !io_wr) psg_op = PSG_RD;
    end

endmodule

// File: rtl/iodec_sys_port.sv
module iodec_sys_port
    import iodec_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int COLS   = 5,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [ROWS-1:0]      row_sel_n,
    input  logic [ROWS*COLS-1:0] key_matrix,
    input  logic                 tape_in,
    output logic [DATA_W-1:0]    rd_byte,
    output logic                 spk_out,
    output logic                 tape_en,
    output logic [BORDER_W-1:0]  border
);

    localparam int SPK_BIT  = 4;
    localparam int TEN_BIT  = 3;
    localparam int TAPE_BIT = 6;

    sys_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.spk     = wdata[SPK_BIT];
            st_d.tape_en = wdata[TEN_BIT];
            st_d.border  = wdata[BORDER_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign spk_out = st_q.spk;
    assign tape_en = st_q.tape_en;
    assign border  = st_q.border;

    // Per-row masking: an unselected row contributes all ones.
    logic [COLS-1:0] row_cols [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_cols[r] = row_sel_n[r] ? {COLS{1'b1}}
                                          : key_matrix[r*COLS +: COLS];
    end

    logic [COLS-1:0] cols_and;

    always_comb begin
        cols_and = {COLS{1'b1}};
        for (int r = 0; r < ROWS; r++) cols_and = cols_and & row_cols[r];
        rd_byte                = {DATA_W{1'b1}};
        rd_byte[COLS-1:0]      = cols_and;
        rd_byte[TAPE_BIT]      = tape_in;
    end

    p_hold_border_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(border) && $stable(spk_out) && $stable(tape_en)));

    p_load_border_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (border == $past(wdata[BORDER_W-1:0])));

endmodule

// File: rtl/iodec_psg_ctrl.sv
module iodec_psg_ctrl
    import iodec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  psg_op_e           op,
    input  logic [DATA_W-1:0] wdata,
    output logic              bdir,
    output logic              bc2,
    output logic              bc1,
    output logic [DATA_W-1:0] dout
);

    typedef struct packed {
        logic              bdir;
        logic              bc2;
        logic              bc1;
        logic [DATA_W-1:0] dout;
    } psg_state_t;

    psg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bdir = 1'b0;
        st_d.bc2  = 1'b0;
        st_d.bc1  = 1'b0;
        unique case (op)
            PSG_SEL: begin
                st_d.bdir = 1'b1;
                st_d.bc2  = 1'b1;
                st_d.bc1  = 1'b1;
                st_d.dout = wdata;
            end
            PSG_WR: begin
                st_d.bdir = 1'b1;
                st_d.bc2  = 1'b1;
                st_d.dout = wdata;
            end
            PSG_RD: begin
                st_d.bc2  = 1'b1;
                st_d.bc1  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bdir = st_q.bdir;
    assign bc2  = st_q.bc2;
    assign bc1  = st_q.bc1;
    assign dout = st_q.dout;

    p_quiet_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op) == PSG_IDLE) |-> ({bdir, bc2, bc1} == 3'b000));

    p_write_bc2_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bdir |-> bc2);

    p_write_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bdir |-> (dout == $past(wdata)));

    p_read_no_bdir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op) == PSG_RD) |-> (!bdir && bc2 && bc1));

endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
    import iodec_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 8,
    parameter int              ROWS     = 8,
    parameter int              COLS     = 5,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 16'hFFFD,
    parameter logic [ADDR_W-1:0] DAT_ADDR = 16'hBFFD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_req,
    input  logic                 io_wr,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic [DATA_W-1:0]    io_wdata,
    input  logic [ROWS*COLS-1:0] key_matrix,
    input  logic                 tape_in,
    input  logic [DATA_W-1:0]    psg_din,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic                 spk_out,
    output logic                 tape_en,
    output logic [BORDER_W-1:0]  border,
    output logic                 psg_bdir,
    output logic                 psg_bc2,
    output logic                 psg_bc1,
    output logic [DATA_W-1:0]    psg_dout
);

    localparam int ROW_LSB = ADDR_W - 8;

    logic    sys_wr, sys_rd;
    psg_op_e psg_op;

    iodec_addr_match #(
        .ADDR_W  (ADDR_W),
        .SEL_ADDR(SEL_ADDR),
        .DAT_ADDR(DAT_ADDR)
    ) u_match (
        .io_req (io_req),
        .io_wr  (io_wr),
        .io_addr(io_addr),
        .sys_wr (sys_wr),
        .sys_rd (sys_rd),
        .psg_op (psg_op)
    );

    typedef struct packed {
        logic              pend;
        logic              sys;
        logic              psg;
        logic [ROWS-1:0]   rows_n;
        logic [DATA_W-1:0] rd_data;
        logic              rd_valid;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [DATA_W-1:0] sys_byte;

    iodec_sys_port #(
        .ROWS  (ROWS),
        .COLS  (COLS),
        .DATA_W(DATA_W)
    ) u_sys (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sys_wr),
        .wdata     (io_wdata),
        .row_sel_n (st_q.rows_n),
        .key_matrix(key_matrix),
        .tape_in   (tape_in),
        .rd_byte   (sys_byte),
        .spk_out   (spk_out),
        .tape_en   (tape_en),
        .border    (border)
    );

    iodec_psg_ctrl #(
        .DATA_W(DATA_W)
    ) u_psg (
        .clk  (clk),
        .rst_n(rst_n),
        .op   (psg_op),
        .wdata(io_wdata),
        .bdir (psg_bdir),
        .bc2  (psg_bc2),
        .bc1  (psg_bc1),
        .dout (psg_dout)
    );

    always_comb begin
        st_d          = st_q;
        st_d.pend     = io_req && !io_wr;
        st_d.sys      = sys_rd;
        st_d.psg      = (psg_op == PSG_RD);
        st_d.rows_n   = io_addr[ROW_LSB +: ROWS];
        st_d.rd_valid = st_q.pend;
        if (st_q.pend) begin
            st_d.rd_data = (st_q.sys ? sys_byte : {DATA_W{1'b1}})
                         & (st_q.psg ? psg_din  : {DATA_W{1'b1}});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.rows_n  <= '1;
            st_q.rd_data <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.rd_data;
    assign rd_valid = st_q.rd_valid;

    p_valid_from_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(io_req && !io_wr, 2));

    p_data_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data));

    p_psg_read_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (psg_bc1 && !psg_bdir) |=> (rd_valid && rd_data == $past(psg_din)));

endmodule

// File: tb/test_io_port_decoder.sv
module test_io_port_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [39:0] key_matrix = '1;
    logic        tape_in = 1'b0;
    logic [7:0]  psg_din = '0;
    logic [7:0]  rd_data;
    logic        rd_valid, spk_out, tape_en;
    logic [2:0]  border;
    logic        psg_bdir, psg_bc2, psg_bc1;
    logic [7:0]  psg_dout;

    io_port_decoder i_io_port_decoder (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata), .key_matrix(key_matrix),
        .tape_in(tape_in), .psg_din(psg_din), .rd_data(rd_data),
        .rd_valid(rd_valid), .spk_out(spk_out), .tape_en(tape_en),
        .border(border), .psg_bdir(psg_bdir), .psg_bc2(psg_bc2),
        .psg_bc1(psg_bc1), .psg_dout(psg_dout)
    );

    always #2 clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic       m_spk = 0, m_ten = 0;
    logic [2:0] m_border = 0;

    task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(logic [15:0] a, logic [39:0] km,
                                            logic tp, logic [7:0] pd);
        logic [7:0] v;
        logic [4:0] c;
        v = 8'hFF;
        if (!a[0]) begin
            c = 5'h1F;
            for (int r = 0; r < 8; r++) if (!a[8+r]) c = c & km[r*5 +: 5];
            v = {1'b1, tp, 1'b1, c};
        end
        if (a == 16'hFFFD) v = v & pd;
        return v;
    endfunction

    function automatic logic [2:0] exp_lines(bit wr, logic [15:0] a);
        if (wr && a == 16'hFFFD) return 3'b111;
        if (wr && a == 16'hBFFD) return 3'b110;
        if (!wr && a == 16'hFFFD) return 3'b011;
        return 3'b000;
    endfunction

    task automatic access(bit wr, logic [15:0] a, logic [7:0] d);
        logic [2:0] el;
        logic [7:0] er;
        el = exp_lines(wr, a);
        er = exp_read(a, key_matrix, tape_in, psg_din);
        @(negedge clk);
        io_req = 1; io_wr = wr; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_req = 0;
        if (wr && !a[0]) begin
            m_spk = d[4]; m_ten = d[3]; m_border = d[2:0];
        end
        chk({psg_bdir, psg_bc2, psg_bc1} == el,
            el == 3'b111 ? "R6" : el == 3'b110 ? "R7" : el == 3'b011 ? "R8" : "R9",
            {13'b0, psg_bdir, psg_bc2, psg_bc1}, {13'b0, el});
        if (el[2]) chk(psg_dout == d, el[0] ? "R6" : "R7", {8'b0, psg_dout}, {8'b0, d});
        chk({spk_out, tape_en, border} == {m_spk, m_ten, m_border},
            (wr && !a[0]) ? "R2" : "R3",
            {11'b0, spk_out, tape_en, border}, {11'b0, m_spk, m_ten, m_border});
        @(negedge clk);
        chk(rd_valid == !wr, "R11", {15'b0, rd_valid}, {15'b0, !wr});
        if (!wr)
            chk(rd_data == er,
                a == 16'hFFFD ? "R8" : a[0] ? "R10" : "R4_R5",
                {8'b0, rd_data}, {8'b0, er});
        chk({psg_bdir, psg_bc2, psg_bc1} == 3'b000, "R9",
            {13'b0, psg_bdir, psg_bc2, psg_bc1}, 16'h0);
        @(negedge clk);
        chk(rd_valid == 0, "R11", {15'b0, rd_valid}, 16'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] a;
        int sel;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk({spk_out, tape_en, border} == 5'b0, "R1", {11'b0, spk_out, tape_en, border}, 16'h0);
        chk({psg_bdir, psg_bc2, psg_bc1, rd_valid} == 4'b0, "R1",
            {12'b0, psg_bdir, psg_bc2, psg_bc1, rd_valid}, 16'h0);
        chk(rd_data == 8'hFF, "R1", {8'b0, rd_data}, 16'h00FF);
        rst_n = 1;
        @(negedge clk);

        // R2 even write, other bits vary
        access(1, 16'h00FE, 8'h1D);
        access(1, 16'hFF00, 8'hE2);
        // R3 odd write ignored
        access(1, 16'h7FFD, 8'hFF);
        // R4 no rows selected, one row, several rows
        key_matrix = 40'h00_0000_0000;
        access(0, 16'hFFFE, 8'h00);
        key_matrix = '1; key_matrix[2*5 +: 5] = 5'b10110;
        access(0, 16'hFBFE, 8'h00);
        key_matrix[7*5 +: 5] = 5'b01111;
        access(0, 16'h7BFE, 8'h00);
        access(0, 16'h00FE, 8'h00);
        // R5 tape level
        tape_in = 1;
        access(0, 16'hFEFE, 8'h00);
        tape_in = 0;
        // R6 R7 R8 PSG accesses
        access(1, 16'hFFFD, 8'h0E);
        access(1, 16'hBFFD, 8'hA5);
        psg_din = 8'h5A;
        access(0, 16'hFFFD, 8'h00);
        // R9 near misses, R10 odd reads
        access(1, 16'hFFFF, 8'h33);
        access(1, 16'hBFFC, 8'h33);
        access(0, 16'hBFFD, 8'h00);
        access(0, 16'h1234 | 16'h1, 8'h00);

        for (int i = 0; i < 400; i++) begin
            key_matrix = {$urandom, $urandom} ;
            tape_in = 1'($urandom);
            psg_din = 8'($urandom);
            sel = $urandom % 6;
            case (sel)
                0: a = 16'hFFFD;
                1: a = 16'hBFFD;
                2: a = 16'($urandom) & 16'hFFFE;
                3: a = 16'($urandom) | 16'h0001;
                4: a = 16'hFFFD ^ (16'h1 << ($urandom % 16));
                default: a = {8'($urandom), 8'hFE};
            endcase
            access(1'($urandom), a, 8'($urandom));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule